// File: doc/BRIEF.md
# ADC Strobe Trigger Edge Controller

This block turns a strobe on an external pin into the control pulses that start an ADC acquisition and conversion. The pin is brought into the clock domain through a two-flop synchronizer. A 3-bit select field then either passes the strobe through unchanged or inverts it. After that stage, a rising edge of the conditioned strobe is the active (sampling) edge and a falling edge is the leading edge. Any other select code turns pin triggering off.

A mode bit chooses one of two schemes. In single-edge operation only the active edge matters, and it starts a sample-and-convert. In dual-edge operation the leading edge first raises the ADC-enable level and starts acquisition. The active edge that follows then samples and starts the conversion. A conversion stays busy until the ADC reports completion. An active edge that arrives while a conversion is busy is dropped and sets a sticky overrun flag.

The pin may also be driven by a timer output. When the timer output is enabled, the level the timer drives is what the synchronizer sees, so a timer pulse can act as its own trigger.

Top module: `adc_strobe_trigger`

## Requirements
- R1: With `trig_sel` = 3'b100 the strobe is used directly: a rising edge of the strobe source is the active edge and a falling edge is the leading edge.
- R2: With `trig_sel` = 3'b101 the strobe is inverted: a falling edge of the strobe source is the active edge and a rising edge is the leading edge.
- R3: With any other `trig_sel` code, edges of the strobe source produce no `acq_start` or `conv_start` pulse, `overrun` is not set and `adc_en` stays 0.
- R4: A strobe change driven between clock edges shows its pulse after the third rising clock edge that follows it. Each `acq_start` and `conv_start` pulse is exactly one cycle high.
- R5: With `dual_mode` = 0, an active edge while idle gives one `conv_start` pulse. A leading edge gives nothing, and `adc_en` stays 0.
- R6: With `dual_mode` = 1, a leading edge while idle gives one `acq_start` pulse and sets `adc_en` to 1 in the same cycle.
- R7: With `dual_mode` = 1, an active edge while idle gives one `conv_start` pulse, and `adc_en` stays 1 while the conversion is busy.
- R8: A `conv_start` makes the conversion busy until `conv_done` is high at a rising clock edge. That edge also clears `adc_en`, and the cleared value is visible in the next cycle.
- R9: While a conversion is busy, an active edge gives no pulse and sets `overrun`, which stays 1 until reset. A leading edge while busy gives no pulse.
- R10: With `tmr_oe` = 1 the strobe source is `tmr_out` and `strobe_pin` is ignored. With `tmr_oe` = 0 the source is `strobe_pin`.
- R11: During reset and in the cycle after it all outputs are 0. Edges are not detected until the synchronizer has settled, so a strobe held at a fixed level through reset never gives a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_pin | input | 1 | Raw external strobe pin, asynchronous |
| tmr_out | input | 1 | Timer output level that drives the pin |
| tmr_oe | input | 1 | Timer output enable; 1 selects `tmr_out` as strobe source |
| trig_sel | input | 3 | Trigger select: 100 direct, 101 inverted, other codes off |
| dual_mode | input | 1 | 0 single-edge, 1 dual-edge |
| conv_done | input | 1 | Conversion complete from the ADC |
| acq_start | output | 1 | One-cycle pulse: start acquisition |
| conv_start | output | 1 | One-cycle pulse: sample and start conversion |
| adc_en | output | 1 | ADC enable level (dual-edge mode) |
| overrun | output | 1 | Sticky flag: active edge lost while busy |

## Verification
The bench sweeps all eight select codes in both modes and with both strobe sources. Each combination runs through the same edge sequence:
- an active edge from idle;
- a conversion-done;
- a leading edge followed by an active edge;
- a leading edge and an active edge while busy;
- a closing conversion-done.

Comparing direct and inverted codes on the same raw sequence shows whether the polarity is applied. The disabled codes show that the gate works. Edges while busy separate dropping a trigger from queueing it. Toggling the raw pin while the timer drives the source shows that the pin is ignored. Each pulse must appear in exactly the third cycle and be one cycle wide, so an extra or missing register stage is caught.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic [2:0] {
        TSEL_PIN     = 3'b100,
        TSEL_PIN_INV = 3'b101
    } tsel_e;

    typedef struct packed {
        logic lead;
        logic act;
    } strobe_ev_t;

    function automatic logic tsel_valid(input logic [2:0] sel);
        return (sel == TSEL_PIN) || (sel == TSEL_PIN_INV);
    endfunction

    function automatic logic tsel_condition(input logic [2:0] sel, input logic raw);
        return raw ^ (sel == TSEL_PIN_INV);
    endfunction

endpackage

// File: rtl/stc_sync.sv
module stc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/stc_edge.sv
module stc_edge
    import stc_pkg::*;
#(
    parameter int PRIME = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       level,
    input  logic       arm,
    output strobe_ev_t ev
);
    localparam int CW = $clog2(PRIME + 1);
    localparam logic [CW-1:0] PRIME_V = CW'(PRIME);

    logic          lvl_q;
    logic [CW-1:0] settle_cnt;
    logic          ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q      <= 1'b0;
            settle_cnt <= '0;
        end else begin
            lvl_q <= level;
            if (settle_cnt != PRIME_V) settle_cnt <= settle_cnt + 1'b1;
        end
    end

    assign ready   = (settle_cnt == PRIME_V);
    assign ev.act  = ready & arm &  level & ~lvl_q;
    assign ev.lead = ready & arm & ~level &  lvl_q;

    // R4: an active edge cannot repeat on the following cycle
    a_r4_act_spaced: assert property (@(posedge clk) disable iff (rst)
        ev.act |=> !ev.act);
endmodule

// File: rtl/stc_seq.sv
module stc_seq
    import stc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  strobe_ev_t ev,
    input  logic       dual_mode,
    input  logic       conv_done,
    output logic       acq_start,
    output logic       conv_start,
    output logic       adc_en,
    output logic       overrun
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acq_start  <= 1'b0;
            conv_start <= 1'b0;
            adc_en     <= 1'b0;
            overrun    <= 1'b0;
            busy_q     <= 1'b0;
        end else begin
            acq_start  <= 1'b0;
            conv_start <= 1'b0;
            if (conv_done) begin
                busy_q <= 1'b0;
                adc_en <= 1'b0;
            end
            if (ev.act) begin
                if (busy_q) begin
                    overrun <= 1'b1;
                end else begin
                    conv_start <= 1'b1;
                    busy_q     <= 1'b1;
                end
            end
            if (dual_mode && ev.lead && !busy_q) begin
                acq_start <= 1'b1;
                adc_en    <= 1'b1;
            end
        end
    end

    // R4: pulses last one cycle
    a_r4_conv_one_cycle: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);
    a_r4_acq_one_cycle: assert property (@(posedge clk) disable iff (rst)
        acq_start |=> !acq_start);
    // R5: no acquisition pulse in single-edge mode
    a_r5_no_acq_single: assert property (@(posedge clk) disable iff (rst)
        acq_start |-> $past(dual_mode));
    // R8: conversion start leaves the block busy
    a_r8_busy_after_conv: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy_q);
    // R8: done without a new leading edge drops the enable
    a_r8_done_clears_en: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !ev.lead) |=> !adc_en);
    // R9: overrun is sticky and only rises while busy
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
    a_r9_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(busy_q));
endmodule

// File: rtl/adc_strobe_trigger.sv
module adc_strobe_trigger
    import stc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_pin,
    input  logic       tmr_out,
    input  logic       tmr_oe,
    input  logic [2:0] trig_sel,
    input  logic       dual_mode,
    input  logic       conv_done,
    output logic       acq_start,
    output logic       conv_start,
    output logic       adc_en,
    output logic       overrun
);
    localparam int PRIME = SYNC_STAGES + 1;

    logic       pin_level;
    logic       pin_sync;
    logic       cond_level;
    strobe_ev_t ev;

    assign pin_level = tmr_oe ? tmr_out : strobe_pin;

    stc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_level),
        .q   (pin_sync)
    );

    assign cond_level = tsel_condition(trig_sel, pin_sync);

    stc_edge #(.PRIME(PRIME)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (cond_level),
        .arm   (tsel_valid(trig_sel)),
        .ev    (ev)
    );

    stc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .dual_mode  (dual_mode),
        .conv_done  (conv_done),
        .acq_start  (acq_start),
        .conv_start (conv_start),
        .adc_en     (adc_en),
        .overrun    (overrun)
    );

    // R3: pulses only follow a valid select code
    a_r3_conv_needs_sel: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(tsel_valid(trig_sel)));
    a_r3_acq_needs_sel: assert property (@(posedge clk) disable iff (rst)
        acq_start |-> $past(tsel_valid(trig_sel)));
    // R11: quiet right after reset
    a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(acq_start || conv_start || adc_en || overrun));
    // R6: acquisition and conversion never start together
    a_r6_start_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(acq_start && conv_start));
endmodule

// File: tb/adc_strobe_trigger_tb.sv
module adc_strobe_trigger_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe_pin = 1'b0;
    logic       tmr_out = 1'b0;
    logic       tmr_oe = 1'b0;
    logic [2:0] trig_sel = 3'b000;
    logic       dual_mode = 1'b0;
    logic       conv_done = 1'b0;
    logic       acq_start, conv_start, adc_en, overrun;

    int n_checks = 0;
    int n_fail   = 0;
    logic done_flag = 1'b0;

    always #2 clk = ~clk;

    adc_strobe_trigger dut_i (
        .clk(clk), .rst(rst), .strobe_pin(strobe_pin), .tmr_out(tmr_out),
        .tmr_oe(tmr_oe), .trig_sel(trig_sel), .dual_mode(dual_mode),
        .conv_done(conv_done), .acq_start(acq_start), .conv_start(conv_start),
        .adc_en(adc_en), .overrun(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s sel=%0d dual=%0d tmr=%0d actual=%0d expected=%0d",
                     tag, trig_sel, dual_mode, tmr_oe, act, exp);
        end
    endtask

    // Drive the raw strobe source; the non-selected input is left alone.
    task automatic drive_raw(input logic v);
        if (tmr_oe) tmr_out = v;
        else        strobe_pin = v;
    endtask

    // Watch six cycles: a pulse is encoded as count*16 + first cycle index.
    task automatic observe(input string tag, input logic exp_acq, input logic exp_conv);
        int a_cnt = 0, a_idx = 0, c_cnt = 0, c_idx = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (acq_start)  begin a_cnt++; if (a_idx == 0) a_idx = i; end
            if (conv_start) begin c_cnt++; if (c_idx == 0) c_idx = i; end
        end
        chk({tag, " acq_start"},  a_cnt * 16 + a_idx, exp_acq  ? 16 + 3 : 0);
        chk({tag, " conv_start"}, c_cnt * 16 + c_idx, exp_conv ? 16 + 3 : 0);
    endtask

    task automatic pulse_done();
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_case(input logic [2:0] sel, input logic dual, input logic src);
        logic inv, valid, acq_ok;
        inv    = (sel == 3'b101);
        valid  = (sel == 3'b100) || (sel == 3'b101);
        acq_ok = valid && dual;
        @(negedge clk);
        rst = 1'b1;
        trig_sel  = sel;
        dual_mode = dual;
        tmr_oe    = src;
        strobe_pin = inv;
        tmr_out    = inv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset outputs", {acq_start, conv_start, adc_en, overrun}, 0);
        observe("R11 settle", 1'b0, 1'b0);
        // active edge from idle: R1/R2 polarity, R5/R7 conversion start
        drive_raw(~inv);
        observe(valid ? (inv ? "R2 active" : "R1 active") : "R3 active", 1'b0, valid);
        chk("R5 adc_en after active", adc_en, 0);
        pulse_done();
        // leading edge from idle: R6 acquisition
        drive_raw(inv);
        observe(dual ? "R6 leading" : "R5 leading", acq_ok, 1'b0);
        chk("R6 adc_en after leading", adc_en, acq_ok);
        drive_raw(~inv);
        observe("R7 active after acq", 1'b0, valid);
        chk("R7 adc_en held busy", adc_en, acq_ok);
        // edges while busy: R9
        drive_raw(inv);
        observe("R9 leading busy", 1'b0, 1'b0);
        drive_raw(~inv);
        observe("R9 active busy", 1'b0, 1'b0);
        chk("R9 overrun set", overrun, valid);
        pulse_done();
        chk("R8 adc_en cleared", adc_en, 0);
        chk("R9 overrun sticky", overrun, valid);
        // after done the block is idle again
        drive_raw(inv);
        observe("R8 idle after done", acq_ok, 1'b0);
        pulse_done();
        if (src) begin
            strobe_pin = ~strobe_pin;
            observe("R10 pin ignored", 1'b0, 1'b0);
            strobe_pin = ~strobe_pin;
            observe("R10 pin ignored", 1'b0, 1'b0);
            tmr_out = ~inv;
            observe("R10 timer trigger", 1'b0, valid);
        end
    endtask

    initial begin
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < 2; d++)
                for (int c = 0; c < 8; c++)
                    run_case(3'(c), d[0], s[0]);
        done_flag = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done_flag);
            end
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule